// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar and raises an alarm interrupt when the time matches a programmed alarm. Elsewhere in the chip, a calendar keeps the time. It supplies the current seconds, minutes, hours, day of month, month and a three-digit year, all in BCD, together with a one-cycle strobe that marks each one-second advance. On each strobe the block compares every selected calendar field with its programmed alarm value. The alarm fires when any selected field matches.

Software programs the block through a simple write port. The port carries six alarm value registers, a control register and an interrupt-pending register. The control register holds one select bit per field and a global enable. A hit sets a sticky pending bit, and the interrupt line follows that bit as a level. Software clears the pending bit by writing a one to its position.

Top module: `alarm_match`

## Requirements
- R1: After reset the alarm interrupt is low, and the control register and all alarm fields are zero, so no strobe can raise the alarm until software programs the block.
- R2: Write addresses are decoded as 0 = pending (clear), 1 = control (bits 6:0), 2 = seconds, 3 = minutes, 4 = hours, 5 = day of month, 6 = month, 7 = year.
- R3: Control bits 0, 1, 2, 3, 4 and 5 select seconds, minutes, hours, day of month, month and year for comparison. A field whose bit is clear never causes a hit.
- R4: Control bit 6 is the global enable. While it is clear, no strobe raises the alarm, whatever the field values.
- R5: A hit occurs when at least one selected field equals its alarm value (an OR over the selected fields).
- R6: Alarm writes keep only the low bits of the write data: 7 bits for seconds and minutes, 6 for hours and day, 5 for month and 12 for year. Higher data bits are dropped.
- R7: The year is a 12-bit BCD value: bits 7:0 hold the two low digits and bits 11:8 hold the hundreds digit. All 12 bits must match for a year hit.
- R8: Comparison happens only in cycles where the one-second strobe is high, using the calendar inputs of that cycle. The interrupt goes high on the cycle after the strobe edge.
- R9: The interrupt is a level that stays high until a write to address 0 with data bit 1 set. That write drops it on the next cycle. A write to address 0 with bit 1 clear has no effect.
- R10: If a hit and a clear write occur in the same cycle, the pending bit stays set. A register write takes effect only for strobes after the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| sec_tick | input | 1 | One-second update strobe |
| cal_sec | input | 7 | Current seconds, BCD |
| cal_min | input | 7 | Current minutes, BCD |
| cal_hour | input | 6 | Current hours, BCD |
| cal_day | input | 6 | Current day of month, BCD |
| cal_mon | input | 5 | Current month, BCD |
| cal_year | input | 12 | Current year, three BCD digits |
| alarm_irq | output | 1 | Alarm interrupt, high while pending |

## Verification
The only result is the interrupt level, and it is due one cycle after the edge that carries a strobe or a clear write. The bench drives each vector on a falling edge, lets one rising edge pass, and compares the interrupt on the next falling edge. The reference model updates its own copy of the registers in the same step, after it has evaluated the hit with the values held before the write. This makes same-cycle writes, hits and clears land exactly where R10 places them.

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          sec_tick,
  input  logic [6:0]    cal_sec,
  input  logic [6:0]    cal_min,
  input  logic [5:0]    cal_hour,
  input  logic [5:0]    cal_day,
  input  logic [4:0]    cal_mon,
  input  logic [11:0]   cal_year,
  output logic          alarm_irq
);
  localparam logic [AW-1:0] A_PEND = AW'(0);
  localparam logic [AW-1:0] A_CTRL = AW'(1);
  localparam logic [AW-1:0] A_SEC  = AW'(2);
  localparam logic [AW-1:0] A_MIN  = AW'(3);
  localparam logic [AW-1:0] A_HOUR = AW'(4);
  localparam logic [AW-1:0] A_DAY  = AW'(5);
  localparam logic [AW-1:0] A_MON  = AW'(6);
  localparam logic [AW-1:0] A_YEAR = AW'(7);
  localparam int GEN_BIT = 6;
  localparam int CLR_BIT = 1;

  logic [6:0]  ctrl_q;
  logic [6:0]  al_sec, al_min;
  logic [5:0]  al_hour, al_day;
  logic [4:0]  al_mon;
  logic [11:0] al_year;
  logic        pend_q;
  logic [5:0]  eq;
  logic        hit, clr;

  assign eq = {cal_year == al_year, cal_mon == al_mon, cal_day == al_day,
               cal_hour == al_hour, cal_min == al_min, cal_sec == al_sec};
  assign hit = sec_tick && ctrl_q[GEN_BIT] && |(eq & ctrl_q[5:0]);
  assign clr = wr_en && wr_addr == A_PEND && wr_data[CLR_BIT];
  assign alarm_irq = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      al_sec  <= '0;
      al_min  <= '0;
      al_hour <= '0;
      al_day  <= '0;
      al_mon  <= '0;
      al_year <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_q  <= wr_data[6:0];
        A_SEC:  al_sec  <= wr_data[6:0];
        A_MIN:  al_min  <= wr_data[6:0];
        A_HOUR: al_hour <= wr_data[5:0];
        A_DAY:  al_day  <= wr_data[5:0];
        A_MON:  al_mon  <= wr_data[4:0];
        A_YEAR: al_year <= wr_data[11:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pend_q <= 1'b0;
    else if (hit) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  // R8
  no_tick_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(alarm_irq));
  // R4
  gen_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[GEN_BIT] && !clr) |=> $stable(alarm_irq));
  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !(sec_tick && ctrl_q[GEN_BIT])) |=> !alarm_irq);
  // R10
  hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && ctrl_q[GEN_BIT] && (ctrl_q[0] && cal_sec == al_sec)) |=> alarm_irq);
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_irq && !clr) |=> alarm_irq);
endmodule

// File: tb/test_alarm_match.sv
module test_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, sec_tick = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic [6:0] cal_sec = 0, cal_min = 0;
  logic [5:0] cal_hour = 0, cal_day = 0;
  logic [4:0] cal_mon = 0;
  logic [11:0] cal_year = 0;
  logic alarm_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [6:0] m_ctrl, m_sec, m_min;
  logic [5:0] m_hour, m_day;
  logic [4:0] m_mon;
  logic [11:0] m_year;
  logic m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_match i_alarm_match (.*);

  function automatic logic model_hit();
    logic [5:0] e;
    e = {cal_year == m_year, cal_mon == m_mon, cal_day == m_day,
         cal_hour == m_hour, cal_min == m_min, cal_sec == m_sec};
    return sec_tick && m_ctrl[6] && |(e & m_ctrl[5:0]);
  endfunction

  task automatic model_reset();
    m_ctrl = 0; m_sec = 0; m_min = 0; m_hour = 0; m_day = 0;
    m_mon = 0; m_year = 0; m_pend = 0;
  endtask

  task automatic model_step();
    logic h;
    h = model_hit();
    if (h) m_pend = 1;
    else if (wr_en && wr_addr == 0 && wr_data[1]) m_pend = 0;
    if (wr_en)
      case (wr_addr)
        3'd1: m_ctrl = wr_data[6:0];
        3'd2: m_sec  = wr_data[6:0];
        3'd3: m_min  = wr_data[6:0];
        3'd4: m_hour = wr_data[5:0];
        3'd5: m_day  = wr_data[5:0];
        3'd6: m_mon  = wr_data[4:0];
        3'd7: m_year = wr_data[11:0];
        default: ;
      endcase
  endtask

  task automatic check(string req);
    n_chk++;
    if (alarm_irq !== m_pend) begin
      n_bad++;
      $display("FAIL %s: alarm_irq=%0b expected=%0b", req, alarm_irq, m_pend);
    end
  endtask

  task automatic cycle(string req);
    model_step();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; sec_tick = 0;
    check(req);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, string req);
    wr_en = 1; wr_addr = a; wr_data = d;
    cycle(req);
  endtask

  task automatic set_cal(logic [6:0] s, logic [6:0] mi, logic [5:0] h,
                         logic [5:0] d, logic [4:0] mo, logic [11:0] y);
    cal_sec = s; cal_min = mi; cal_hour = h; cal_day = d; cal_mon = mo; cal_year = y;
  endtask

  task automatic tick(string req);
    sec_tick = 1;
    cycle(req);
  endtask

  task automatic wr_clear(string req);
    wr(3'd0, 16'h0002, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: expired, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 reset irq low");
    set_cal(0, 0, 0, 0, 0, 0);
    tick("R1 reset fields zero, ctrl zero");
    wr(3'd1, 16'h0040, "R1 gen only");
    tick("R1 no fields selected after reset");

    // R3 / R5 seconds
    wr(3'd2, 16'h0045, "R2 seconds write");
    wr(3'd1, 16'h0041, "R2 ctrl write");
    set_cal(7'h45, 7'h11, 0, 0, 0, 0);
    tick("R3 seconds hit");
    tick("R9 level stays");
    wr(3'd0, 16'hFFFD, "R9 write bit1 clear no effect");
    wr_clear("R9 clear");
    // R4 global enable clear
    wr(3'd1, 16'h003F, "R4 ctrl");
    tick("R4 global off");
    // R3 unselected field
    wr(3'd3, 16'h0011, "R2 min");
    wr(3'd1, 16'h0041, "R3 ctrl sec only");
    set_cal(7'h44, 7'h11, 0, 0, 0, 0);
    tick("R3 unselected minute match ignored");
    // R5 OR
    wr(3'd1, 16'h0043, "R5 ctrl");
    tick("R5 OR minute hit");
    wr_clear("R9 clear");
    // R6 mask
    wr(3'd2, 16'hFF85, "R6 masked seconds");
    wr(3'd1, 16'h0041, "R6 ctrl");
    set_cal(7'h05, 0, 0, 0, 0, 0);
    tick("R6 seconds upper bits dropped");
    wr_clear("R9 clear");
    // R7 year
    wr(3'd7, 16'hF123, "R7 year");
    wr(3'd1, 16'h0060, "R7 ctrl");
    set_cal(0, 0, 0, 0, 0, 12'h023);
    tick("R7 hundreds digit mismatch");
    set_cal(0, 0, 0, 0, 0, 12'h123);
    tick("R7 full year hit");
    wr_clear("R9 clear");
    // R8 no strobe
    set_cal(0, 0, 0, 0, 0, 12'h123);
    cycle("R8 no strobe no hit");
    // R10 hit and clear together
    sec_tick = 1; wr_en = 1; wr_addr = 0; wr_data = 16'h0002;
    cycle("R10 hit beats clear");
    // R10 write and tick same cycle uses old value
    wr_clear("R9 clear");
    sec_tick = 1; wr_en = 1; wr_addr = 3'd1; wr_data = 16'h0000;
    cycle("R10 ctrl write same cycle as strobe");
    wr_clear("R9 clear");

    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) begin
        wr_en = 1; wr_addr = 3'($urandom_range(1, 7));
        wr_data = 16'($urandom);
        if (wr_addr == 1) wr_data[6] = ($urandom_range(0, 3) != 0);
      end else if (k == 3) begin
        wr_en = 1; wr_addr = 0; wr_data = 16'($urandom);
      end
      cal_sec  = $urandom_range(0, 1) ? m_sec  : 7'($urandom);
      cal_min  = $urandom_range(0, 1) ? m_min  : 7'($urandom);
      cal_hour = $urandom_range(0, 3) == 0 ? m_hour : 6'($urandom);
      cal_day  = $urandom_range(0, 3) == 0 ? m_day  : 6'($urandom);
      cal_mon  = $urandom_range(0, 3) == 0 ? m_mon  : 5'($urandom);
      cal_year = $urandom_range(0, 3) == 0 ? m_year : 12'($urandom);
      sec_tick = $urandom_range(0, 2) != 0;
      cycle("R3 R4 R5 R6 R8 R9 R10 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule